// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs register read and write transactions against an external Ethernet PHY over the two-wire management interface: a clock line (MDC) and a bidirectional data line (MDIO). The data line is brought out as a split output, output-enable and input triple, so the pad ring or the bench builds the tristate. MDC is made by dividing the system clock. Its half period is `HALF_DIV` system cycles, and the clock only toggles while a transaction is in flight.

A request is offered on a valid/ready port. `req_ready` is high only while the master is idle. A request is taken on the cycle where both `req_valid` and `req_ready` are high. While a frame runs, `req_ready` stays low, so held or changing request fields have no effect, and the caller keeps `req_valid` up until it sees `req_ready`. The response side has no back-pressure. `rsp_done` is a one-cycle pulse, and `rsp_rdata` holds the most recent read result until the next read completes.

Every frame opens with 33 driven ones. Read and write frames then differ in how long the driven header is and in what follows it. A request whose register address does not fit in five bits never reaches the wire.

Top module: `mdio_master`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress, and `busy` is its inverse. After a request is accepted, `req_ready` is low from the next cycle until the done pulse has passed. Request fields presented while busy do not alter the running frame or its result.
- R2: While a frame runs, MDC has a period of 2*`HALF_DIV` system cycles, with `HALF_DIV` cycles low and then `HALF_DIV` cycles high. MDC is low and MDIO is released (`mdio_oe`=0) whenever the master is idle.
- R3: Each accepted frame begins with 33 MDC rising edges at which MDIO is driven to 1.
- R4: A read then drives 16 further bits, MSB first: 1, 1, 0, 1, 1, 0, the PHY address (bit 4 first) and the low five register address bits (bit 4 first).
- R5: A write then drives 32 bits, MSB first: 0, 1, 0, 1, the PHY address, the register address, 1, 0, and the 16 write-data bits (bit 15 first).
- R6: After its header, a read releases MDIO for 19 MDC cycles and samples MDIO just before each rising edge. The samples at the 3rd to 18th released edges form `rsp_rdata`, bit 15 first. The 1st, 2nd and 19th samples are discarded.
- R7: After its 32 data bits, a write releases MDIO for exactly 2 more MDC cycles before it completes. A write frame therefore has 67 rising edges and a read frame has 68.
- R8: A request whose register address is above 31 produces no MDC edge and no MDIO drive. `rsp_done` pulses on the cycle after acceptance. For a read, `rsp_rdata` becomes 0xFFFF. A write is dropped.
- R9: `rsp_done` is high for exactly one system cycle per accepted request. `rsp_rdata` changes only when a read completes, and a write leaves it unchanged.
- R10: `mdio_o` and `mdio_oe` change only while MDC is low. Each new bit appears on the same system edge on which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request will be taken |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_AW | Register address (values above 31 are rejected) |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read result |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach from the ports is the released window of a read. There the result depends on which of the 19 input samples are kept, so an off-by-one in the sampling point or in the bit drop still produces plausible data. The bench therefore models a PHY that counts released rising edges and presents a distinct per-transaction pattern: a pulled-up turnaround bit, a zero, 16 data bits and a pulled-up idle bit. Sweeping every PHY address with arithmetic data patterns, including all-zero and all-one words, exposes any shift of the capture window. The bench also holds conflicting requests on the port during a frame, to show that none of them leaks into it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int MDIO_DW  = 16;
  localparam int MDIO_PW  = 5;
  localparam int MDIO_RW5 = 5;
  localparam int FRAME_W  = 32;
  localparam int RX_BITS  = 19;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_CMD,
    SQ_RX,
    SQ_TAIL,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic sample_stb,
  output logic bit_end
);
  localparam int CW = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
  localparam logic [CW-1:0] SAMP_AT = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] LAST_AT = CW'(2 * HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt <= (cnt == LAST_AT) ? '0 : cnt + 1'b1;
      if (cnt == SAMP_AT)      mdc_q <= 1'b1;
      else if (cnt == LAST_AT) mdc_q <= 1'b0;
    end
  end

  assign mdc        = mdc_q;
  assign sample_stb = run && (cnt == SAMP_AT);
  assign bit_end    = run && (cnt == LAST_AT);

  // R2: a rising MDC edge always follows a sampling strobe
  assert_mdc_rise_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(sample_stb));
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
(
  input  logic                wr,
  input  logic [MDIO_PW-1:0]  phy,
  input  logic [MDIO_RW5-1:0] rg,
  input  logic [MDIO_DW-1:0]  wdata,
  output logic [FRAME_W-1:0]  word,
  output logic [4:0]          last_idx
);
  always_comb begin
    if (wr) begin
      word     = {2'b01, 2'b01, phy, rg, 2'b10, wdata};
      last_idx = 5'd31;
    end else begin
      word     = {2'b11, 2'b01, 2'b10, phy, rg, 16'h0000};
      last_idx = 5'd15;
    end
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              din,
  output logic [MDIO_DW:0]  word
);
  logic [MDIO_DW:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sr <= '0;
    else if (shift_en)   sr <= {sr[MDIO_DW-1:0], din};
  end

  assign word = sr;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int REG_AW  = 6,
  parameter int PRE_LEN = 33
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_wr,
  input  logic [REG_AW-1:0]  req_reg,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [4:0]         tx_last,
  input  logic               bit_end,
  input  logic [MDIO_DW:0]   rx_word,
  output logic               run,
  output logic               req_ready,
  output logic               rsp_done,
  output logic [MDIO_DW-1:0] rsp_rdata,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rx_clear,
  output logic               in_rx
);
  localparam int BMAX = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
  localparam int BCW  = $clog2(BMAX);
  localparam logic [BCW-1:0] RX_LAST   = BCW'(RX_BITS - 1);
  localparam logic [BCW-1:0] TAIL_LAST = BCW'(1);

  seq_state_e         state;
  logic [FRAME_W-1:0] tx_sr;
  logic [BCW-1:0]     bitcnt;
  logic [4:0]         last_q;
  logic               wr_q;
  logic               bad_addr;
  logic               accept;

  assign bad_addr  = req_reg > REG_AW'(31);
  assign req_ready = (state == SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_done  = (state == SQ_DONE);
  assign run       = (state == SQ_PRE) || (state == SQ_CMD) ||
                     (state == SQ_RX)  || (state == SQ_TAIL);
  assign rx_clear  = accept;
  assign in_rx     = (state == SQ_RX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      tx_sr     <= '0;
      bitcnt    <= '0;
      last_q    <= '0;
      wr_q      <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (accept) begin
          wr_q <= req_wr;
          if (bad_addr) begin
            state <= SQ_DONE;
            if (!req_wr) rsp_rdata <= 16'hFFFF;
          end else begin
            state   <= SQ_PRE;
            tx_sr   <= tx_word;
            last_q  <= tx_last;
            bitcnt  <= BCW'(PRE_LEN - 1);
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
          end
        end
        SQ_PRE: if (bit_end) begin
          if (bitcnt == '0) begin
            state  <= SQ_CMD;
            mdio_o <= tx_sr[FRAME_W-1];
            bitcnt <= BCW'(last_q);
          end else begin
            bitcnt <= bitcnt - 1'b1;
          end
        end
        SQ_CMD: if (bit_end) begin
          if (bitcnt == '0) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            if (wr_q) begin
              state  <= SQ_TAIL;
              bitcnt <= TAIL_LAST;
            end else begin
              state  <= SQ_RX;
              bitcnt <= RX_LAST;
            end
          end else begin
            mdio_o <= tx_sr[FRAME_W-2];
            tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
            bitcnt <= bitcnt - 1'b1;
          end
        end
        SQ_RX: if (bit_end) begin
          if (bitcnt == '0) begin
            state     <= SQ_DONE;
            rsp_rdata <= MDIO_DW'(rx_word >> 1);
          end else begin
            bitcnt <= bitcnt - 1'b1;
          end
        end
        SQ_TAIL: if (bit_end) begin
          if (bitcnt == '0) state <= SQ_DONE;
          else              bitcnt <= bitcnt - 1'b1;
        end
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_accept_goes_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rx_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RX) |-> !mdio_oe);

  assert_tail_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_TAIL) |-> !mdio_oe);

  assert_reject_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_addr) |=> (rsp_done && !run));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_done && !$past(rsp_done)) |-> $stable(rsp_rdata));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20,
  parameter int REG_AW   = 6,
  parameter int PRE_LEN  = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [4:0]        req_phy,
  input  logic [REG_AW-1:0] req_reg,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic               run;
  logic               sample_stb;
  logic               bit_end;
  logic [FRAME_W-1:0] tx_word;
  logic [4:0]         tx_last;
  logic [MDIO_DW:0]   rx_word;
  logic               rx_clear;
  logic               in_rx;

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mdc(mdc), .sample_stb(sample_stb), .bit_end(bit_end)
  );

  mdio_frame_build u_frame (
    .wr(req_wr), .phy(req_phy), .rg(req_reg[MDIO_RW5-1:0]), .wdata(req_wdata),
    .word(tx_word), .last_idx(tx_last)
  );

  mdio_rx_capture u_rx (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear),
    .shift_en(in_rx && sample_stb), .din(mdio_i), .word(rx_word)
  );

  mdio_seq #(.REG_AW(REG_AW), .PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_reg(req_reg), .tx_word(tx_word), .tx_last(tx_last),
    .bit_end(bit_end), .rx_word(rx_word), .run(run),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rx_clear(rx_clear), .in_rx(in_rx)
  );

  assign busy = !req_ready;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_mdio_stable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_wr;
  logic [4:0]  req_phy;
  logic [5:0]  req_reg;
  logic [15:0] req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        busy;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic        log_oe [0:255];
  logic        log_o  [0:255];
  int          nlog = 0;
  int          per_errs = 0;
  int          hi_chg = 0;
  int          last_rise = -1;
  int          rel_cnt = 0;
  logic        mdc_prev = 1'b0;
  logic        o_prev = 1'b1;
  logic        oe_prev = 1'b0;
  logic [18:0] pat = '1;
  logic [15:0] last_read = 16'h0000;

  mdio_master #(.HALF_DIV(H), .REG_AW(6), .PRE_LEN(33)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not end, actual cycles %0d expected below %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // PHY model and wire monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mdc && mdc_prev && (mdio_o !== o_prev || mdio_oe !== oe_prev)) hi_chg++;
    if (!busy) last_rise = -1;
    if (mdio_oe) rel_cnt = 0;
    if (mdc && !mdc_prev) begin
      log_oe[nlog % 256] = mdio_oe;
      log_o[nlog % 256]  = mdio_o;
      nlog++;
      if (last_rise >= 0 && (cyc - last_rise) != 2 * H) per_errs++;
      last_rise = cyc;
      if (!mdio_oe) rel_cnt++;
    end
    mdio_i   = (!mdio_oe && rel_cnt < 19) ? pat[18 - rel_cnt] : 1'b1;
    mdc_prev = mdc;
    o_prev   = mdio_o;
    oe_prev  = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [5:0] rg,
                         input logic [15:0] wd, input logic [15:0] pdata, input bit junk);
    int base, prev_per, n, total, exp_total, hdr_len, pre_bad, hdr_bad, rel_bad;
    logic [31:0] field;
    base     = nlog;
    prev_per = per_errs;
    pat      = {1'b1, 1'b0, pdata, 1'b1};
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_wr = wr; req_phy = phy; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    if (junk) begin
      req_wr = !wr; req_phy = ~phy; req_reg = rg ^ 6'h15; req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    if (rg > 31) begin
      chk(rsp_done == 1'b1, "R8", "done one cycle after rejected request", rsp_done, 1);
      chk(nlog == base, "R8", "no MDC edges for rejected request", nlog - base, 0);
      if (!wr) begin
        chk(rsp_rdata == 16'hFFFF, "R8", "rejected read data", rsp_rdata, 16'hFFFF);
        last_read = 16'hFFFF;
      end else begin
        chk(rsp_rdata == last_read, "R8", "rejected write leaves data", rsp_rdata, last_read);
      end
    end else begin
      chk(busy == 1'b1 && req_ready == 1'b0, "R1", "busy after accept", busy, 1);
      n = 0;
      while (!rsp_done && n < 3000) begin
        @(negedge clk);
        n++;
        if (!rsp_done && req_ready) begin
          chk(0, "R1", "ready raised before done", 1, 0);
        end
      end
      chk(rsp_done == 1'b1, "R9", "done pulse seen", rsp_done, 1);
      total     = nlog - base;
      exp_total = wr ? 67 : 68;
      hdr_len   = wr ? 32 : 16;
      field     = wr ? {2'b01, 2'b01, phy, rg[4:0], 2'b10, wd}
                     : {2'b11, 2'b01, 2'b10, phy, rg[4:0], 16'h0000};
      pre_bad = 0; hdr_bad = 0; rel_bad = 0;
      for (int k = 0; k < exp_total && k < total; k++) begin
        if (k < 33) begin
          if (!(log_oe[(base + k) % 256] == 1'b1 && log_o[(base + k) % 256] == 1'b1)) pre_bad++;
        end else if (k < 33 + hdr_len) begin
          if (!(log_oe[(base + k) % 256] == 1'b1 &&
                log_o[(base + k) % 256] == field[31 - (k - 33)])) hdr_bad++;
        end else begin
          if (log_oe[(base + k) % 256] != 1'b0) rel_bad++;
        end
      end
      chk(pre_bad == 0, "R3", "preamble bits wrong", pre_bad, 0);
      chk(hdr_bad == 0, wr ? "R5" : "R4", "header bits wrong", hdr_bad, 0);
      chk(total == exp_total, wr ? "R7" : "R6", "rising edges in frame", total, exp_total);
      chk(rel_bad == 0, wr ? "R7" : "R6", "released bits driven", rel_bad, 0);
      chk(per_errs == prev_per, "R2", "MDC period errors", per_errs - prev_per, 0);
      if (!wr) begin
        chk(rsp_rdata == pdata, junk ? "R1" : "R6", "read data", rsp_rdata, pdata);
        last_read = pdata;
      end else begin
        chk(rsp_rdata == last_read, "R9", "write keeps read data", rsp_rdata, last_read);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_done == 1'b0, "R9", "done lasts one cycle", rsp_done, 0);
    chk(req_ready == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R2", "idle after done",
        {req_ready, mdc, mdio_oe}, 3'b100);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_wr = 1'b0; req_phy = '0; req_reg = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0, "R1", "reset ready", req_ready, 1);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2", "reset wire idle", {mdc, mdio_oe}, 0);
    chk(rsp_done == 1'b0, "R9", "reset done low", rsp_done, 0);

    for (int p = 0; p < 32; p++) begin
      logic [5:0]  rg;
      logic [15:0] d;
      rg = 6'((p * 7) % 32);
      d  = 16'hA5C3 ^ 16'(p * 16'h1111);
      run_txn(1'b0, 5'(p), rg, 16'h0000, d, (p % 4) == 0);
      rg = 6'(31 - p);
      d  = 16'h5AA5 ^ 16'(p * 16'h0801);
      run_txn(1'b1, 5'(p), rg, d, 16'h0000, (p % 4) == 1);
    end
    run_txn(1'b0, 5'd3, 6'd1, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd3, 6'd2, 16'h0000, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'd9, 6'd31, 16'hFFFF, 16'h0000, 1'b0);
    run_txn(1'b1, 5'd9, 6'd0, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd4, 6'd5, 16'h0000, 16'h1234, 1'b0);
    run_txn(1'b1, 5'd4, 6'd32, 16'hBEEF, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd4, 6'd33, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b1, 5'd4, 6'd47, 16'h0F0F, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd4, 6'd63, 16'h0000, 16'h0000, 1'b0);
    run_txn(1'b0, 5'd7, 6'd17, 16'h0000, 16'h8001, 1'b1);

    chk(hi_chg == 0, "R10", "MDIO changes while MDC high", hi_chg, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule